// File: doc/BRIEF.md
# Predicated Find-First Mask Generator

This block turns one bit vector into a mask derived from where its first set bit lies. A source mask is scanned from bit 0 towards the top bit, and the lowest position that is both active and set in the source is taken as the "first" element. From that position the block builds a destination mask in one of three selectable forms: every active position strictly below it set, every active position up to and including it set, or only that position set. Position activity comes from a predicate mask; a separate flag declares the predicate absent, which makes every position active.

Inactive positions take no part in the search, so a source 1 at an inactive position can never be chosen as the first element. Their destination bits are not written either: they pass the old destination value through unchanged. One mode code is reserved and returns the whole old destination. The result is computed combinationally and captured in a register, so the output presents the mask for the inputs sampled at the previous rising clock edge.

Top module: `ffm_mask_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `dst_mask` becomes all zeros at that edge.
- R2: With `mode_sel` = 2'b00 (before-first), each active position below the lowest active position whose source bit is 1 gets 1; that position and every active position above it get 0.
- R3: With `mode_sel` = 2'b00 or 2'b01, if no active position has a source bit of 1, every active position of `dst_mask` is 1.
- R4: With `mode_sel` = 2'b01 (including-first), the result matches R2 except that the first active set position is also 1.
- R5: With `mode_sel` = 2'b10 (only-first), only the lowest active position whose source bit is 1 gets 1; every other active position gets 0.
- R6: With `mode_sel` = 2'b10 and no active source bit of 1, every active position of `dst_mask` is 0.
- R7: A position is active when `pred_off` is 1 or when its bit of `pred_mask` is 1; an inactive position of `dst_mask` takes the corresponding bit of `dst_old`.
- R8: Source bits at inactive positions are ignored when the first set element is searched for.
- R9: When `pred_off` is 1 the value of `pred_mask` has no effect on `dst_mask`.
- R10: `mode_sel` = 2'b11 is reserved and yields `dst_old` unchanged in every position.
- R11: `dst_mask` changes only at a rising clock edge and shows the result for the inputs sampled at that edge; between edges it holds.
- R12: Once the first active set element has been found, no later active position is set again in modes 2'b00 and 2'b01, even when later active source bits are 0 and inactive positions lie in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_mask | input | N | Source bit vector to be scanned |
| pred_mask | input | N | Per-position predicate, 1 = active |
| pred_off | input | 1 | 1 = predicate absent, all positions active |
| dst_old | input | N | Previous destination value, kept at inactive positions |
| mode_sel | input | 2 | 00 before-first, 01 including-first, 10 only-first, 11 reserved |
| dst_mask | output | N | Registered destination mask |

## Verification
Directed vectors use a sparse predicate whose active positions straddle a source 1 at an inactive position, which tells a search that honours the predicate from one that scans raw source bits, and separates the three modes by whether the first element and the positions below it are set. An all-zero source with the predicate absent separates the two set-style modes from only-first, and a single low source 1 followed by interleaved inactive positions shows whether the scan ever re-enters setting. Random vectors with a mix of absent and present predicates, all four mode codes and arbitrary old values are compared every cycle against a behavioural scan, and a held-input step shows the output moves only at the clock edge.

// File: rtl/ffm_pkg.sv
// Shared definitions for the find-first mask generator.
package ffm_pkg;

    // Mode codes; the encoding is visible at the top-level port.
    typedef enum logic [1:0] {
        FFM_BEFORE = 2'b00,  // set active bits below the first element
        FFM_INCL   = 2'b01,  // also set the first element
        FFM_ONLY   = 2'b10,  // set the first element alone
        FFM_KEEP   = 2'b11   // reserved: pass the old destination
    } ffm_mode_e;

endpackage

// File: rtl/ffm_active.sv
// Active-position and hit decode.
// Marks every position that takes part in the operation and those
// active positions that hold a source 1. Assumes pred_off overrides
// the predicate completely.
module ffm_active #(
    parameter int N = 16
) (
    input  logic [N-1:0] src_mask,
    input  logic [N-1:0] pred_mask,
    input  logic         pred_off,
    output logic [N-1:0] active,
    output logic [N-1:0] hit
);

    // Active set: every position when the predicate is absent.
    assign active = pred_off ? {N{1'b1}} : pred_mask;

    // Hits: source 1s that may be chosen as the first element.
    assign hit = src_mask & active;

endmodule

// File: rtl/ffm_prefix.sv
// Prefix-OR network.
// Produces, for each position i, the OR of bits 0..i of its input.
// The caller shifts the hit vector up by one so that the result is
// "some hit strictly below i". FAST selects a log-depth parallel
// prefix; otherwise a linear ripple chain is built. Assumes N >= 2.
module ffm_prefix #(
    parameter int N    = 16,
    parameter bit FAST = 1'b1
) (
    input  logic [N-1:0] bits_in,
    output logic [N-1:0] prefix_or
);

    localparam int LVL = (N > 1) ? $clog2(N) : 1;

    if (FAST) begin : g_tree
        logic [N-1:0] stage [0:LVL];

        // Level 0 is the raw input.
        assign stage[0] = bits_in;

        for (genvar k = 0; k < LVL; k++) begin : g_lvl
            for (genvar i = 0; i < N; i++) begin : g_bit
                if (i >= (1 << k)) begin : g_join
                    // Merge with the span that ends 2^k places lower.
                    assign stage[k+1][i] = stage[k][i] | stage[k][i-(1<<k)];
                end else begin : g_pass
                    // Nothing below to merge at this distance.
                    assign stage[k+1][i] = stage[k][i];
                end
            end
        end

        assign prefix_or = stage[LVL];
    end else begin : g_ripple
        // Linear accumulation from bit 0 upward.
        always_comb begin
            logic acc;
            acc = 1'b0;
            for (int i = 0; i < N; i++) begin
                acc          = acc | bits_in[i];
                prefix_or[i] = acc;
            end
        end
    end

endmodule

// File: rtl/ffm_select.sv
// Per-position result selection.
// Given the active set, the hits, and whether a hit exists strictly
// below each position, forms the next destination bit for the chosen
// mode. Inactive positions and the reserved mode keep dst_old.
module ffm_select
    import ffm_pkg::*;
#(
    parameter int N = 16
) (
    input  ffm_mode_e    mode,
    input  logic [N-1:0] active,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] seen_below,
    input  logic [N-1:0] dst_old,
    output logic [N-1:0] dst_next
);

    logic write_en;

    // Reserved mode writes no position at all.
    assign write_en = (mode != FFM_KEEP);

    for (genvar i = 0; i < N; i++) begin : g_pos
        logic first_here;
        logic before_val;
        logic incl_val;
        logic val;

        // This position is the first active hit.
        assign first_here = hit[i] & ~seen_below[i];
        // Still searching and this is not the hit.
        assign before_val = ~seen_below[i] & ~hit[i];
        // Still searching, or the hit itself.
        assign incl_val   = ~seen_below[i];

        // Mode-dependent value for an active position.
        always_comb begin
            unique case (mode)
                FFM_BEFORE: val = before_val;
                FFM_INCL:   val = incl_val;
                FFM_ONLY:   val = first_here;
                default:    val = dst_old[i];
            endcase
        end

        // Write only active positions in a writing mode.
        assign dst_next[i] = (write_en && active[i]) ? val : dst_old[i];
    end

endmodule

// File: rtl/ffm_mask_gen.sv
// Predicated find-first mask generator, top level.
// Decodes active positions, finds the lowest active source 1 with a
// prefix-OR network, forms the destination mask for the selected mode
// and registers it. Synchronous active-low reset clears the output.
// Assumes N >= 2.
module ffm_mask_gen
    import ffm_pkg::*;
#(
    parameter int N         = 16,
    parameter bit FAST_SCAN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_mask,
    input  logic [N-1:0] pred_mask,
    input  logic         pred_off,
    input  logic [N-1:0] dst_old,
    input  logic [1:0]   mode_sel,
    output logic [N-1:0] dst_mask
);

    logic [N-1:0] active;
    logic [N-1:0] hit;
    logic [N-1:0] hit_up;
    logic [N-1:0] seen_below;
    logic [N-1:0] dst_next;
    ffm_mode_e    mode;

    // Mode code taken from the port.
    assign mode = ffm_mode_e'(mode_sel);

    ffm_active #(.N(N)) u_active (
        .src_mask  (src_mask),
        .pred_mask (pred_mask),
        .pred_off  (pred_off),
        .active    (active),
        .hit       (hit)
    );

    // Shift hits up one place so the prefix means "strictly below".
    assign hit_up = {hit[N-2:0], 1'b0};

    ffm_prefix #(.N(N), .FAST(FAST_SCAN)) u_prefix (
        .bits_in   (hit_up),
        .prefix_or (seen_below)
    );

    ffm_select #(.N(N)) u_select (
        .mode       (mode),
        .active     (active),
        .hit        (hit),
        .seen_below (seen_below),
        .dst_old    (dst_old),
        .dst_next   (dst_next)
    );

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_mask <= '0;
        end else begin
            dst_mask <= dst_next;
        end
    end

endmodule

// File: rtl/ffm_mask_gen_chk.sv
// Property checker for ffm_mask_gen, attached with bind below.
// Relates sampled port values to the registered output one cycle later.
module ffm_mask_gen_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] src_mask,
    input logic [N-1:0] pred_mask,
    input logic         pred_off,
    input logic [N-1:0] dst_old,
    input logic [1:0]   mode_sel,
    input logic [N-1:0] dst_mask
);

    logic [N-1:0] act_c;

    // Active positions as seen from the ports.
    assign act_c = pred_off ? {N{1'b1}} : pred_mask;

    // R1: reset clears the output at the next edge.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> dst_mask == '0);

    // R10: reserved mode passes the old destination.
    a_r10_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel == 2'b11 |=> dst_mask == $past(dst_old));

    // R7: inactive positions hold dst_old.
    a_r7_inactive_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dst_mask ^ $past(dst_old)) & ~$past(act_c)) == '0);

    // R5: only-first sets at most one active position.
    a_r5_single_first: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel == 2'b10 |=> $onehot0(dst_mask & $past(act_c)));

    // R3: no active hit in a set-style mode fills the active set.
    a_r3_fill_active: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[1] == 1'b0 && (src_mask & act_c) == '0)
        |=> (dst_mask & $past(act_c)) == $past(act_c));

    // R6: no active hit in only-first clears the active set.
    a_r6_none_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10 && (src_mask & act_c) == '0)
        |=> (dst_mask & $past(act_c)) == '0);

    // R11: output holds when inputs were held and no reset intervened.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(src_mask) && $stable(pred_mask) && $stable(pred_off)
         && $stable(dst_old) && $stable(mode_sel) && $past(rst_n))
        |=> $stable(dst_mask));

endmodule

bind ffm_mask_gen ffm_mask_gen_chk #(.N(N)) u_ffm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_mask  (src_mask),
    .pred_mask (pred_mask),
    .pred_off  (pred_off),
    .dst_old   (dst_old),
    .mode_sel  (mode_sel),
    .dst_mask  (dst_mask)
);

// File: tb/test_ffm_mask_gen.sv
// Bench for ffm_mask_gen: directed cases plus a per-cycle behavioural model.
module test_ffm_mask_gen;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] src_mask = '0;
    logic [W-1:0] pred_mask = '0;
    logic         pred_off = 1'b0;
    logic [W-1:0] dst_old = '0;
    logic [1:0]   mode_sel = 2'b00;
    logic [W-1:0] dst_mask;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;  // 250 MHz

    ffm_mask_gen #(.N(W)) i_ffm_mask_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_mask  (src_mask),
        .pred_mask (pred_mask),
        .pred_off  (pred_off),
        .dst_old   (dst_old),
        .mode_sel  (mode_sel),
        .dst_mask  (dst_mask)
    );

    // Behavioural scan: walk positions upward with a searching flag.
    function automatic logic [W-1:0] model(input logic [W-1:0] s,
                                           input logic [W-1:0] p,
                                           input logic off,
                                           input logic [W-1:0] o,
                                           input logic [1:0] m);
        logic [W-1:0] r;
        bit searching;
        r = o;
        searching = 1;
        if (m == 2'b11) return o;
        for (int i = 0; i < W; i++) begin
            if (off || p[i]) begin
                if (!searching) r[i] = 1'b0;
                else if (s[i]) begin
                    r[i] = (m != 2'b00) && (m != 2'b11);
                    searching = 0;
                end else r[i] = (m != 2'b10);
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] exp);
        n_chk++;
        if (dst_mask !== exp) begin
            n_bad++;
            $display("FAIL %s: dst_mask=%h expected=%h", tag, dst_mask, exp);
        end
    endtask

    // Apply one vector at a falling edge, check at the next falling edge.
    task automatic step(input logic [W-1:0] s, input logic [W-1:0] p,
                        input logic off, input logic [W-1:0] o,
                        input logic [1:0] m, input string tag,
                        input logic [W-1:0] exp);
        src_mask = s; pred_mask = p; pred_off = off; dst_old = o; mode_sel = m;
        @(negedge clk);
        check(tag, exp);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset with inputs that would otherwise fill the mask.
        pred_off = 1'b1; mode_sel = 2'b01; dst_old = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1", 8'h00);
        rst_n = 1'b1;

        // R2: sparse predicate, first active hit at bit 7 (old = 3C).
        step(8'h94, 8'hC3, 1'b0, 8'h3C, 2'b00, "R2", 8'h7F);
        // R4: same vector, first element also set.
        step(8'h94, 8'hC3, 1'b0, 8'h3C, 2'b01, "R4", 8'hFF);
        // R5: first active hit at bit 6 only.
        step(8'hD4, 8'hC3, 1'b0, 8'h3C, 2'b10, "R5", 8'h7C);
        // R3: no predicate, empty source, before-first.
        step(8'h00, 8'h00, 1'b1, 8'h00, 2'b00, "R3", 8'hFF);
        // R3: empty source, including-first.
        step(8'h00, 8'h00, 1'b1, 8'h00, 2'b01, "R3", 8'hFF);
        // R6: empty source, only-first.
        step(8'h00, 8'h00, 1'b1, 8'hFF, 2'b10, "R6", 8'h00);
        // R8: source 1s only at inactive positions do not stop the search.
        step(8'hF0, 8'h0F, 1'b0, 8'h00, 2'b00, "R8", 8'h0F);
        // R7: inactive positions keep old bits in only-first mode.
        step(8'h08, 8'h0F, 1'b0, 8'hA0, 2'b10, "R7", 8'hA8);
        // R9: predicate ignored when flagged absent.
        step(8'h10, 8'h01, 1'b1, 8'h00, 2'b01, "R9", 8'h1F);
        // R12: hit at bit 0, inactive bit 1 in between, never re-enters.
        step(8'h01, 8'hFD, 1'b0, 8'h02, 2'b00, "R12", 8'h02);
        step(8'h01, 8'hFD, 1'b0, 8'h02, 2'b01, "R12", 8'h03);
        // R10: reserved mode.
        step(8'hFF, 8'hFF, 1'b1, 8'h5A, 2'b11, "R10", 8'h5A);
        // R11: output waits for the edge.
        step(8'h00, 8'h00, 1'b0, 8'hAA, 2'b11, "R11", 8'hAA);
        dst_old = 8'h55;
        #1;
        check("R11", 8'hAA);
        @(negedge clk);
        check("R11", 8'h55);

        // Random vectors compared every cycle against the model.
        for (int t = 0; t < 400; t++) begin
            logic [W-1:0] s, p, o;
            logic off;
            logic [1:0] m;
            string tg;
            s = W'($urandom); p = W'($urandom); o = W'($urandom);
            off = ($urandom % 4) == 0;
            m = 2'($urandom);
            if (t % 7 == 0) s = s & ~p;  // hits only at inactive places
            case (m)
                2'b00: tg = "R2";
                2'b01: tg = "R4";
                2'b10: tg = "R5";
                default: tg = "R10";
            endcase
            step(s, p, off, o, m, tg, model(s, p, off, o, m));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule